// File: doc/BRIEF.md
# Fixed Message Partition Controller

This block runs the fixed-message mode of a voice record/playback store. A 3-bit partition code, captured while reset is high, splits a 128-row storage array into one to eight messages. The split follows a fixed table of row counts, not an even division. Each message has its own active-low select line. A mode line, also captured in reset, sets the operation for every select. With the mode line low, a select records while it is held. With the mode line high, a select starts playback on one press and stops it on the next.

While an operation runs, the block presents the first row and the row count of the partition in use. It also presents the absolute row being worked on, which advances on a row-done strobe from the storage side. It drives the write enable, the read enable and a one-cycle end-marker write, together with an active-low indicator and a power-down flag. The storage array and the audio path sit outside the block. The storage side reports a marker found during playback through an input.

Top module: `fixed_msg_partition`

## Requirements
- R1: While reset is high and in the first cycle after it, the block is idle: `pwr_dn`=1, `led_n`=1, `mem_wr_en`=`mem_rd_en`=`mark_wr`=0, and `part_base`, `part_rows` and `cur_row` read 0.
- R2: Partition code v selects v+1 messages. Their row counts are as follows. v=0: 128. v=1: 64,64. v=2: 44,42,42. v=3: 32×4. v=4: 26,26,26,26,24. v=5: 23 then 21×5. v=6: 20 then 18×6. v=7: 16×8. Message i starts at the sum of the counts of messages 0..i-1, so start plus count never exceeds 128.
- R3: In record mode (`play_sel`=0 at reset), a high-to-low change on an enabled `msg_n[i]` starts a recording one cycle later. `mem_wr_en`=1, `led_n`=0, and `part_base`/`part_rows` show partition i. Recording continues while the select stays low.
- R4: Recording ends on the cycle after the select is seen high, or after the row-done strobe for the partition's last row. One cycle with `mark_wr`=1 and `led_n`=1 then follows at the current row, and the block then returns to idle.
- R5: In playback mode (`play_sel`=1 at reset), a high-to-low change on an enabled select starts playback one cycle later with `mem_rd_en`=1. A second high-to-low change on the same select returns the block to idle one cycle later, with no indicator pulse.
- R6: Playback ends naturally on `eom_hit`, or after the row-done strobe for the partition's last row. `led_n` is then low for `PULSE_LEN` cycles (default 4) before the block returns to idle.
- R7: A select numbered at or above the configured message count has no effect. The block stays idle.
- R8: If several selects fall in the same idle cycle, the lowest-numbered one wins. While an operation runs, changes on every other select are ignored.
- R9: The partition code and the mode line are sampled only while reset is high. Changes to them afterwards have no effect.
- R10: During an operation, `cur_row` equals `part_base` plus the number of rows completed so far in that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; captures `cfg_code` and `play_sel` |
| cfg_code | input | 3 | Partition code: v+1 messages |
| play_sel | input | 1 | 0 = level-held recording, 1 = toggled playback |
| msg_n | input | 8 | Active-low message selects, bit i for message i |
| row_done | input | 1 | One-cycle strobe from storage: current row finished |
| eom_hit | input | 1 | Playback met an end-of-message marker |
| part_base | output | 7 | First row of the active partition (0 when idle) |
| part_rows | output | 8 | Row count of the active partition (0 when idle) |
| cur_row | output | 7 | Absolute row being accessed (0 when idle) |
| mem_wr_en | output | 1 | Recording write enable |
| mem_rd_en | output | 1 | Playback read enable |
| mark_wr | output | 1 | One-cycle end-marker write at `cur_row` |
| led_n | output | 1 | Active-low indicator |
| pwr_dn | output | 1 | High while idle |

## Verification
Every input change sits one register away from the outputs. A select edge, a release, a row-done strobe or an `eom_hit` changes the outputs on the first rising edge after it. The bench therefore drives each input on a falling edge and checks the outputs on the next falling edge. The marker write is checked exactly one cycle after the release or the final strobe, and idle one cycle after that. The indicator pulse is counted over `PULSE_LEN` consecutive falling edges, and idle is checked on the edge after the last one.

// File: rtl/fmp_pkg.sv
package fmp_pkg;

    localparam int ARRAY_ROWS = 128;
    localparam int CODE_W     = 3;
    localparam int NMSG       = 1 << CODE_W;
    localparam int ADDR_W     = $clog2(ARRAY_ROWS);
    localparam int CNT_W      = ADDR_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REC,
        ST_MARK,
        ST_PLAY,
        ST_PULSE
    } fmp_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  rows;
    } part_t;

    // Row count of message idx when the code selects code+1 messages
    function automatic logic [CNT_W-1:0] part_rows_f(input logic [CODE_W-1:0] code,
                                                     input int unsigned idx);
        logic [CNT_W-1:0] r;
        if (idx > int'(code)) begin
            r = '0;
        end else begin
            case (code)
                3'd0:    r = CNT_W'(128);
                3'd1:    r = CNT_W'(64);
                3'd2:    r = (idx == 0) ? CNT_W'(44) : CNT_W'(42);
                3'd3:    r = CNT_W'(32);
                3'd4:    r = (idx == 4) ? CNT_W'(24) : CNT_W'(26);
                3'd5:    r = (idx == 0) ? CNT_W'(23) : CNT_W'(21);
                3'd6:    r = (idx == 0) ? CNT_W'(20) : CNT_W'(18);
                default: r = CNT_W'(16);
            endcase
        end
        return r;
    endfunction

    // First row of message idx: running sum of the lower partitions
    function automatic logic [CNT_W-1:0] part_base_f(input logic [CODE_W-1:0] code,
                                                     input int unsigned idx);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int unsigned j = 0; j < NMSG; j++) begin
            if (j < idx) s = s + part_rows_f(code, j);
        end
        return s;
    endfunction

endpackage

// File: rtl/fmp_alloc.sv
module fmp_alloc
    import fmp_pkg::*;
(
    input  logic [CODE_W-1:0]     code,
    output part_t [NMSG-1:0]      parts,
    output logic  [NMSG-1:0]      enabled
);

    for (genvar g = 0; g < NMSG; g++) begin : g_part
        logic [CNT_W-1:0] base_full;
        assign base_full       = part_base_f(code, g);
        assign parts[g].base   = base_full[ADDR_W-1:0];
        assign parts[g].rows   = part_rows_f(code, g);
        assign enabled[g]      = (g <= int'(code));
    end

endmodule

// File: rtl/fmp_pick.sv
module fmp_pick
    import fmp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NMSG-1:0]       msg_n,
    input  logic [NMSG-1:0]       enabled,
    output logic [NMSG-1:0]       fall,
    output logic                  any_start,
    output logic [CODE_W-1:0]     start_idx
);

    logic [NMSG-1:0] prev_n;
    logic [NMSG-1:0] cand;

    always_ff @(posedge clk) begin
        if (rst) prev_n <= '1;
        else     prev_n <= msg_n;
    end

    assign fall = prev_n & ~msg_n;
    assign cand = fall & enabled;

    // Lowest-numbered candidate wins
    always_comb begin
        start_idx = '0;
        for (int i = NMSG - 1; i >= 0; i--) begin
            if (cand[i]) start_idx = CODE_W'(i);
        end
    end

    assign any_start = |cand;

endmodule

// File: rtl/fmp_seq.sv
module fmp_seq
    import fmp_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_play,
    input  logic                  any_start,
    input  logic [CODE_W-1:0]     start_idx,
    input  part_t [NMSG-1:0]      parts,
    input  logic [NMSG-1:0]       fall,
    input  logic [NMSG-1:0]       msg_n,
    input  logic                  row_done,
    input  logic                  eom_hit,
    output logic [ADDR_W-1:0]     part_base,
    output logic [CNT_W-1:0]      part_rows,
    output logic [ADDR_W-1:0]     cur_row,
    output logic                  mem_wr_en,
    output logic                  mem_rd_en,
    output logic                  mark_wr,
    output logic                  led_n,
    output logic                  pwr_dn
);

    localparam int PC_W = $clog2(PULSE_LEN) + 1;

    fmp_state_e          st;
    logic [CODE_W-1:0]   idx;
    part_t               act;
    logic [CNT_W-1:0]    cnt;
    logic [PC_W-1:0]     pcnt;
    logic                last_row;

    assign last_row = (cnt == act.rows - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            idx  <= '0;
            act  <= '0;
            cnt  <= '0;
            pcnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (any_start) begin
                        idx  <= start_idx;
                        act  <= parts[start_idx];
                        cnt  <= '0;
                        st   <= mode_play ? ST_PLAY : ST_REC;
                    end
                end
                ST_REC: begin
                    if (msg_n[idx])                 st <= ST_MARK;
                    else if (row_done && last_row)  st <= ST_MARK;
                    else if (row_done)              cnt <= cnt + CNT_W'(1);
                end
                ST_MARK: begin
                    st <= ST_IDLE;
                end
                ST_PLAY: begin
                    if (fall[idx]) begin
                        st <= ST_IDLE;
                    end else if (eom_hit || (row_done && last_row)) begin
                        st   <= ST_PULSE;
                        pcnt <= '0;
                    end else if (row_done) begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_PULSE: begin
                    pcnt <= pcnt + PC_W'(1);
                    if (pcnt == PC_W'(PULSE_LEN - 1)) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    logic busy;
    logic [CNT_W-1:0] row_sum;
    assign busy      = (st != ST_IDLE);
    assign row_sum   = CNT_W'(act.base) + cnt;
    assign part_base = busy ? act.base : '0;
    assign part_rows = busy ? act.rows : '0;
    assign cur_row   = busy ? row_sum[ADDR_W-1:0] : '0;
    assign mem_wr_en = (st == ST_REC);
    assign mem_rd_en = (st == ST_PLAY);
    assign mark_wr   = (st == ST_MARK);
    assign led_n     = !((st == ST_REC) || (st == ST_PULSE));
    assign pwr_dn    = !busy;

endmodule

// File: rtl/fixed_msg_partition.sv
module fixed_msg_partition
    import fmp_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CODE_W-1:0]     cfg_code,
    input  logic                  play_sel,
    input  logic [NMSG-1:0]       msg_n,
    input  logic                  row_done,
    input  logic                  eom_hit,
    output logic [ADDR_W-1:0]     part_base,
    output logic [CNT_W-1:0]      part_rows,
    output logic [ADDR_W-1:0]     cur_row,
    output logic                  mem_wr_en,
    output logic                  mem_rd_en,
    output logic                  mark_wr,
    output logic                  led_n,
    output logic                  pwr_dn
);

    logic [CODE_W-1:0] code_q;
    logic              mode_q;

    // Configuration is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= cfg_code;
            mode_q <= play_sel;
        end
    end

    part_t [NMSG-1:0]  parts;
    logic  [NMSG-1:0]  enabled;
    logic  [NMSG-1:0]  fall;
    logic              any_start;
    logic [CODE_W-1:0] start_idx;

    fmp_alloc u_alloc (
        .code    (code_q),
        .parts   (parts),
        .enabled (enabled)
    );

    fmp_pick u_pick (
        .clk       (clk),
        .rst       (rst),
        .msg_n     (msg_n),
        .enabled   (enabled),
        .fall      (fall),
        .any_start (any_start),
        .start_idx (start_idx)
    );

    fmp_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_play (mode_q),
        .any_start (any_start),
        .start_idx (start_idx),
        .parts     (parts),
        .fall      (fall),
        .msg_n     (msg_n),
        .row_done  (row_done),
        .eom_hit   (eom_hit),
        .part_base (part_base),
        .part_rows (part_rows),
        .cur_row   (cur_row),
        .mem_wr_en (mem_wr_en),
        .mem_rd_en (mem_rd_en),
        .mark_wr   (mark_wr),
        .led_n     (led_n),
        .pwr_dn    (pwr_dn)
    );

endmodule

// File: rtl/fmp_checker.sv
module fmp_checker
    import fmp_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     part_base,
    input logic [CNT_W-1:0]      part_rows,
    input logic [ADDR_W-1:0]     cur_row,
    input logic                  mem_wr_en,
    input logic                  mem_rd_en,
    input logic                  mark_wr,
    input logic                  led_n,
    input logic                  pwr_dn
);

    logic [CNT_W:0] part_end;
    assign part_end = {2'b00, part_base} + {1'b0, part_rows};

    AST_PART_FITS: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn |-> (part_end <= (CNT_W+1)'(ARRAY_ROWS)));  // R2

    AST_ROW_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en || mem_rd_en || mark_wr) |->
            (cur_row >= part_base && {2'b00, cur_row} < part_end));  // R10

    AST_REC_ENDS_MARK: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |=> (mem_wr_en || mark_wr));  // R4

    AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mark_wr |=> (!mark_wr && pwr_dn));  // R4

    AST_LED_DURING_REC: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> !led_n);  // R3

    AST_PART_HELD: assert property (@(posedge clk) disable iff (rst)
        !pwr_dn |=> (pwr_dn || $stable(part_base)));  // R8

    AST_NO_MIX: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr_en, mem_rd_en, mark_wr}));  // R5

endmodule

bind fixed_msg_partition fmp_checker u_chk (.*);

// File: tb/fixed_msg_partition_bench.sv
module fixed_msg_partition_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_code = 3'd0;
    logic       play_sel = 1'b0;
    logic [7:0] msg_n = 8'hFF;
    logic       row_done = 1'b0;
    logic       eom_hit = 1'b0;
    logic [6:0] part_base;
    logic [7:0] part_rows;
    logic [6:0] cur_row;
    logic       mem_wr_en, mem_rd_en, mark_wr, led_n, pwr_dn;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fixed_msg_partition u_fixed_msg_partition (
        .clk(clk), .rst(rst), .cfg_code(cfg_code), .play_sel(play_sel),
        .msg_n(msg_n), .row_done(row_done), .eom_hit(eom_hit),
        .part_base(part_base), .part_rows(part_rows), .cur_row(cur_row),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en), .mark_wr(mark_wr),
        .led_n(led_n), .pwr_dn(pwr_dn)
    );

    // Expected size table, written per message count
    function automatic int exp_rows(input int code, input int k);
        int n;
        n = code + 1;
        if (k >= n) return 0;
        if (n == 3) return (k == 0) ? 44 : 42;
        if (n == 5) return (k == 4) ? 24 : 26;
        if (n == 6) return (k == 0) ? 23 : 21;
        if (n == 7) return (k == 0) ? 20 : 18;
        return 128 / n;
    endfunction

    function automatic int exp_base(input int code, input int k);
        int s;
        s = 0;
        for (int j = 0; j < k; j++) s += exp_rows(code, j);
        return s;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic reset_dut(input int code, input bit play);
        rst = 1'b1; cfg_code = 3'(code); play_sel = play;
        msg_n = 8'hFF; row_done = 1'b0; eom_hit = 1'b0;
        tick(); tick();
        rst = 1'b0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        reset_dut(0, 0);
        chk("R1 pwr_dn", pwr_dn, 1);
        chk("R1 led_n", led_n, 1);
        chk("R1 enables", {mem_wr_en, mem_rd_en, mark_wr}, 0);
        chk("R1 base/rows", part_base + part_rows + cur_row, 0);

        // R2 R3 R4 R7: sweep every code and every select in record mode
        for (int c = 0; c < 8; c++) begin
            reset_dut(c, 0);
            for (int k = 0; k < 8; k++) begin
                msg_n[k] = 1'b0;
                tick();
                if (k <= c) begin
                    chk("R3 wr_en", mem_wr_en, 1);
                    chk("R3 led_n", led_n, 0);
                    chk("R2 base", part_base, exp_base(c, k));
                    chk("R2 rows", part_rows, exp_rows(c, k));
                    chk("R2 fits", (part_base + part_rows <= 128) ? 1 : 0, 1);
                    msg_n[k] = 1'b1;
                    tick();
                    chk("R4 mark_wr", mark_wr, 1);
                    chk("R4 mark row", cur_row, exp_base(c, k));
                    chk("R4 led off", led_n, 1);
                    tick();
                    chk("R4 idle", pwr_dn, 1);
                end else begin
                    chk("R7 ignored pwr_dn", pwr_dn, 1);
                    chk("R7 ignored wr_en", mem_wr_en, 0);
                    msg_n[k] = 1'b1;
                    tick();
                end
            end
        end

        // R4 R10: record to the last row of partition 7 with eight messages
        reset_dut(7, 0);
        msg_n[7] = 1'b0;
        tick();
        for (int r = 0; r < 16; r++) begin
            chk("R10 cur_row", cur_row, 112 + r);
            chk("R3 held wr_en", mem_wr_en, 1);
            row_done = 1'b1;
            tick();
            row_done = 1'b0;
        end
        chk("R4 end mark_wr", mark_wr, 1);
        chk("R4 end row", cur_row, 127);
        msg_n[7] = 1'b1;
        tick();
        chk("R4 end idle", pwr_dn, 1);

        // R8 R5: playback, priority and second trigger
        reset_dut(3, 1);
        msg_n = ~8'b0000_1010;
        tick();
        chk("R8 lowest wins base", part_base, 32);
        chk("R5 rd_en", mem_rd_en, 1);
        chk("R5 no wr_en", mem_wr_en, 0);
        msg_n = 8'hFF;
        tick();
        msg_n[0] = 1'b0;
        tick();
        chk("R8 other ignored base", part_base, 32);
        chk("R8 other ignored rd_en", mem_rd_en, 1);
        msg_n = 8'hFF;
        tick();
        msg_n[1] = 1'b0;
        tick();
        chk("R5 toggle stop pwr_dn", pwr_dn, 1);
        chk("R5 no pulse", led_n, 1);
        msg_n = 8'hFF;
        tick();

        // R6: natural end on marker
        msg_n[2] = 1'b0;
        tick();
        chk("R5 start base", part_base, 64);
        msg_n[2] = 1'b1;
        eom_hit = 1'b1;
        tick();
        eom_hit = 1'b0;
        for (int p = 0; p < 4; p++) begin
            chk("R6 pulse low", led_n, 0);
            tick();
        end
        chk("R6 pulse over", led_n, 1);
        chk("R6 idle", pwr_dn, 1);

        // R6: natural end at the last row
        reset_dut(7, 1);
        msg_n[0] = 1'b0;
        tick();
        msg_n[0] = 1'b1;
        for (int r = 0; r < 16; r++) begin
            row_done = 1'b1;
            tick();
            row_done = 1'b0;
        end
        chk("R6 last row pulse", led_n, 0);
        chk("R10 last row", cur_row, 15);
        repeat (4) tick();
        chk("R6 last row idle", pwr_dn, 1);

        // R9: configuration changes after reset are ignored
        reset_dut(1, 0);
        cfg_code = 3'd7; play_sel = 1'b1;
        msg_n[5] = 1'b0;
        tick();
        chk("R9 old count kept", pwr_dn, 1);
        msg_n = 8'hFF;
        tick();
        msg_n[1] = 1'b0;
        tick();
        chk("R9 record mode kept", mem_wr_en, 1);
        chk("R9 old rows kept", part_rows, 64);
        msg_n = 8'hFF;
        tick(); tick();

        // Random record runs: R3 R4 R7 R10
        for (int it = 0; it < 40; it++) begin
            int c, k, h;
            c = int'($urandom % 8);
            k = int'($urandom % 8);
            h = int'($urandom % 6);
            reset_dut(c, 0);
            msg_n[k] = 1'b0;
            tick();
            if (k <= c) begin
                for (int r = 0; r < h; r++) begin
                    row_done = 1'b1;
                    tick();
                    row_done = 1'b0;
                end
                chk("R10 random row", cur_row, exp_base(c, k) + h);
                msg_n[k] = 1'b1;
                tick();
                chk("R4 random mark", mark_wr, 1);
                chk("R4 random mark row", cur_row, exp_base(c, k) + h);
            end else begin
                chk("R7 random ignored", pwr_dn, 1);
                msg_n[k] = 1'b1;
            end
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule